// File: doc/BRIEF.md
# Converter Sample Word Formatter with Overrange Flag

This block sits between a 14-bit converter core and the output pins. Each clock it accepts one raw two's-complement sample and, after a fixed pipeline delay, presents a 14-bit output word. The word has two layouts. In flag layout, the top 13 bits carry the upper 13 bits of the sample and bit 0 carries an overrange flag. In full-data layout, all 14 bits carry the sample and no flag is present.

The flag has two sources. The saturation source marks a sample that sits at either end of the code range. It travels down the same pipeline as the data, so it always appears in the word of the sample it describes. The early source compares the sample magnitude against a 3-bit threshold given in eighths of full scale. It reaches the output only seven clock edges after capture. Because the data latency is longer than seven edges, this early flag leads the data it belongs to.

The layout select and the source select are registered at each clock edge. While reset is asserted they take their default values: flag layout, with the early source selected. The data latency is a parameter.

Top module: `adc_word_fmt`

## Requirements
- R1: With full_data_i registered low, word_o[13:1] equals bits 13..1 of the sample captured LAT-1 edges before the edge that produced the word. At the default LAT of 10, this is the sample presented 10 edges earlier, counting its own capture edge.
- R2: With full_data_i registered high, word_o[13:0] equals the whole sample captured LAT-1 edges earlier, and no flag appears in bit 0.
- R3: In flag layout with fast_sel_i registered low, word_o[0] is 1 exactly when the sample whose data bits are in the same word equals 14'h1FFF or 14'h2000.
- R4: In flag layout with fast_sel_i registered high, word_o[0] reflects the sample captured 6 edges earlier, which is 7 edges including its capture. The flag is 1 when that sample's magnitude is greater than or equal to thr_i*1024, using the thr_i value presented together with that sample. The code 14'h2000 has magnitude 8192, and thr_i = 0 always asserts the flag.
- R5: A change on full_data_i or fast_sel_i alters the layout of the word produced by the next clock edge and of no earlier word.
- R6: While rst_ni is low, word_o is all zeros. After reset is released, words whose samples predate the release show zero data bits and a zero flag from the cleared pipeline.
- R7: LAT must be greater than 7, so that the early flag always leads its own data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | 14 | Raw two's-complement sample from the converter core |
| thr_i | input | 3 | Early-flag threshold in eighths of full scale, captured with each sample |
| full_data_i | input | 1 | 1: all 14 bits carry data; 0: bit 0 carries the flag |
| fast_sel_i | input | 1 | 1: early threshold flag drives bit 0; 0: saturation flag drives bit 0 |
| word_o | output | 14 | Formatted output word |

## Verification
In the early-flag mode, a single output word combines the data of one sample with the flag of a sample captured LAT-7 edges later. Because of this, a saturating sample and an unrelated threshold crossing can land in the same word. The stimulus forces this overlap by injecting saturation codes and codes just above and just below thr_i*1024, while the source select and the layout select toggle at random edges. Each word is judged against a history of the driven inputs. The data is looked up LAT-1 edges back, the early flag 6 edges back, and the controls at the latest edge. Words produced right after a control change are tagged separately.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
package adc_fmt_pkg;
  localparam int FAST_LAT = 7;

  typedef struct packed {
    logic full_data;
    logic fast_sel;
  } fmt_cfg_t;

  localparam fmt_cfg_t CFG_RST = '{full_data: 1'b0, fast_sel: 1'b1};
endpackage

// File: rtl/ovr_detect.sv
`timescale 1ns/1ps
module ovr_detect #(
  parameter int W     = 14,
  parameter int THR_W = 3
) (
  input  logic [W-1:0]     smp_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             sat_o,
  output logic             fast_o
);
  localparam int SH = W - 1 - THR_W;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mag;
  logic [W-1:0] lim;

  assign sat_o  = (smp_i == POS_MAX) || (smp_i == NEG_MAX);
  // unsigned magnitude; most negative code maps to 2^(W-1)
  assign mag    = smp_i[W-1] ? (~smp_i + 1'b1) : smp_i;
  assign lim    = {1'b0, thr_i, {SH{1'b0}}};
  assign fast_o = (mag >= lim);
endmodule

// File: rtl/dly_line.sv
`timescale 1ns/1ps
module dly_line #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/word_pack.sv
`timescale 1ns/1ps
module word_pack
  import adc_fmt_pkg::*;
#(
  parameter int W = 14
) (
  input  logic [W-1:0] data_i,
  input  logic         sat_i,
  input  logic         fast_i,
  input  fmt_cfg_t     cfg_i,
  output logic [W-1:0] word_o
);
  logic flag;

  assign flag = cfg_i.fast_sel ? fast_i : sat_i;

  always_comb begin
    word_o = data_i;
    if (!cfg_i.full_data) word_o[0] = flag;
  end
endmodule

// File: rtl/adc_word_fmt.sv
`timescale 1ns/1ps
module adc_word_fmt
  import adc_fmt_pkg::*;
#(
  parameter int W     = 14,
  parameter int LAT   = 10,
  parameter int THR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     smp_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             full_data_i,
  input  logic             fast_sel_i,
  output logic [W-1:0]     word_o
);
  fmt_cfg_t     cfg_q;
  logic         hit_sat, hit_fast;
  logic [W-1:0] data_last;
  logic         sat_last, fast_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= '{full_data: full_data_i, fast_sel: fast_sel_i};
  end

  ovr_detect #(.W(W), .THR_W(THR_W)) u_det (
    .smp_i (smp_i),
    .thr_i (thr_i),
    .sat_o (hit_sat),
    .fast_o(hit_fast)
  );

  dly_line #(.WIDTH(W), .DEPTH(LAT)) u_data_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(smp_i), .q_o(data_last)
  );

  // saturation flag rides alongside the data
  dly_line #(.WIDTH(1), .DEPTH(LAT)) u_sat_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hit_sat), .q_o(sat_last)
  );

  dly_line #(.WIDTH(1), .DEPTH(FAST_LAT)) u_fast_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hit_fast), .q_o(fast_last)
  );

  word_pack #(.W(W)) u_pack (
    .data_i(data_last),
    .sat_i (sat_last),
    .fast_i(fast_last),
    .cfg_i (cfg_q),
    .word_o(word_o)
  );
endmodule

// File: rtl/adc_word_fmt_chk.sv
`timescale 1ns/1ps
module adc_word_fmt_chk
  import adc_fmt_pkg::*;
#(
  parameter int W   = 14,
  parameter int LAT = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         full_data_i,
  input logic         fast_sel_i,
  input logic         hit_fast,
  input logic         fast_last,
  input logic         sat_last,
  input logic [W-1:0] data_last,
  input logic [W-1:0] word_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic [3:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 4'hF) cyc_q <= cyc_q + 1'b1;
  end

  // R7
  initial lat_order_chk: assert (LAT > FAST_LAT);

  // R3
  sat_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_last == ((data_last == POS_MAX) || (data_last == NEG_MAX)));

  // R4
  fast_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'(FAST_LAT)) |-> fast_last == $past(hit_fast, 7));

  // R2
  full_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd1 && $past(full_data_i)) |-> word_o == data_last);

  // R5
  src_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd1 && !$past(full_data_i) && $past(fast_sel_i)) |-> word_o[0] == fast_last);

  // R6
  rst_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> word_o == '0);
endmodule

bind adc_word_fmt adc_word_fmt_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .full_data_i(full_data_i),
  .fast_sel_i (fast_sel_i),
  .hit_fast   (hit_fast),
  .fast_last  (fast_last),
  .sat_last   (sat_last),
  .data_last  (data_last),
  .word_o     (word_o)
);

// File: tb/adc_word_fmt_test.sv
`timescale 1ns/1ps
module adc_word_fmt_test;
  localparam int W   = 14;
  localparam int LAT = 10;
  localparam int N   = 3000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] smp_i = '0;
  logic [2:0]   thr_i = '0;
  logic         full_data_i = 1'b0;
  logic         fast_sel_i = 1'b1;
  logic [W-1:0] word_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W-1:0] s_h [N];
  logic [2:0]   t_h [N];
  bit           d_h [N];
  bit           f_h [N];

  always #5 clk_i = ~clk_i;

  adc_word_fmt #(.W(W), .LAT(LAT), .THR_W(3)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .thr_i(thr_i),
    .full_data_i(full_data_i), .fast_sel_i(fast_sel_i), .word_o(word_o)
  );

  function automatic bit is_sat(logic [W-1:0] v);
    return (v == 14'h1FFF) || (v == 14'h2000);
  endfunction

  function automatic bit fast_hit(logic [W-1:0] v, logic [2:0] th);
    logic [W-1:0] m;
    m = v[W-1] ? (~v + 14'd1) : v;
    return int'(m) >= int'(th) * 1024;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_word(int t);
    logic [W-1:0] dd;
    logic         ef;
    bool_chg: begin end
    if (t - LAT + 1 >= 0) dd = s_h[t-LAT+1];
    else                  dd = '0;
    if (t - LAT + 1 < 0)
      chk("R6 data cleared", {1'b0, word_o[W-1:1]}, {1'b0, dd[W-1:1]});
    else if (d_h[t])
      chk("R2 full data", word_o, dd);
    else
      chk("R1 upper data", {1'b0, word_o[W-1:1]}, {1'b0, dd[W-1:1]});
    if (d_h[t]) return;
    if (f_h[t]) ef = (t - 6 >= 0) ? fast_hit(s_h[t-6], t_h[t-6]) : 1'b0;
    else        ef = (t - LAT + 1 >= 0) ? is_sat(dd) : 1'b0;
    if (t >= 1 && (f_h[t] != f_h[t-1] || d_h[t] != d_h[t-1]))
      chk("R5 select switch", 14'(word_o[0]), 14'(ef));
    else if (f_h[t])
      chk("R4 early flag", 14'(word_o[0]), 14'(ef));
    else
      chk("R3 saturation flag", 14'(word_o[0]), 14'(ef));
  endtask

  task automatic drive(int i);
    logic [W-1:0] v;
    int r;
    if (i < 48) begin
      case (i % 8)
        0: v = 14'h1FFF;
        1: v = 14'h2000;
        2: v = 14'h1FFE;
        3: v = 14'(int'(thr_i) * 1024);
        4: v = 14'(int'(thr_i) * 1024 - 1);
        5: v = 14'(-(int'(thr_i) * 1024));
        6: v = 14'(-(int'(thr_i) * 1024) + 1);
        default: v = 14'h0000;
      endcase
      if (i % 8 == 7) thr_i = 3'(thr_i + 3);
      if (i == 16) fast_sel_i = 1'b0;
      if (i == 32) full_data_i = 1'b1;
      if (i == 40) begin full_data_i = 1'b0; fast_sel_i = 1'b1; thr_i = 3'd0; end
    end else begin
      r = int'($urandom % 16);
      if (r == 0)      v = 14'h1FFF;
      else if (r == 1) v = 14'h2000;
      else if (r < 5)  v = 14'(int'(thr_i) * 1024 + int'($urandom % 3) - 1) ^ ((r == 4) ? 14'h3FFF : 14'h0);
      else             v = 14'($urandom);
      if ($urandom % 16 == 0) full_data_i = ~full_data_i;
      if ($urandom % 8 == 0)  fast_sel_i  = ~fast_sel_i;
      if ($urandom % 32 == 0) thr_i       = 3'($urandom);
    end
    smp_i = v;
    s_h[i] = v;
    t_h[i] = thr_i;
    d_h[i] = full_data_i;
    f_h[i] = fast_sel_i;
  endtask

  initial begin
    void'($urandom(32'd5813));
    rst_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      smp_i = 14'($urandom);
      thr_i = 3'($urandom);
      chk("R6 reset zero", word_o, '0);
    end
    @(negedge clk_i);
    smp_i = '0; thr_i = 3'd2; full_data_i = 1'b0; fast_sel_i = 1'b1;
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (i >= 1) check_word(i - 1);
      drive(i);
      @(negedge clk_i);
    end
    check_word(N - 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule